// File: doc/BRIEF.md
# Scan-Chain to Serial-Flash Bridge

This block sits behind a user data register of a JTAG test access port and converts the bit stream of one DR scan into a single SPI transaction to a serial flash. The host shifts a frame made of three parts. First comes a 1 bit that marks the start of the frame. The next 32 bits give the transfer length. The payload follows, and each payload bit becomes one SPI clock. Any number of zeros from BYPASS registers ahead of the bridge may precede the marker. Any number of flush bits may follow the payload. The bridge therefore works without knowing its position in the chain.

The bridge data register is one bit long. Outside a transfer, TDO returns TDI one shift cycle later. During a transfer, TDO returns the flash output bit that was sampled at each rising SCLK edge. SCLK is a gated copy of TCK. MOSI and the gate change on the falling edge of TCK, which gives mode 0 timing at the flash.

Top module: `scan_flash_bridge`

## Requirements
- R1: While the bridge is deselected, or before it has seen a 1 bit on TDI in shift-DR, it stays in search. Zeros, and bits shifted while deselected, never assert CS_N.
- R2: The 32 TDI bits that follow the marker are taken as the transfer length, most significant bit first.
- R3: For a length L > 0, CS_N is low for exactly L TCK cycles and SCLK shows exactly L rising edges, all while CS_N is low. CS_N goes low at the falling TCK edge after the first payload bit is sampled.
- R4: The bit driven on MOSI at the k-th rising SCLK edge is the k-th payload TDI bit (k counted from 0). MOSI changes only on falling TCK edges.
- R5: Once L payload bits have been taken, CS_N returns high. Any further shift bits in the same scan produce no SCLK edge.
- R6: Outside the SCLK window, the TDO value seen at a rising TCK edge equals the TDI value taken at the previous rising edge.
- R7: The MISO value sampled at a rising SCLK edge is presented on TDO at the next rising TCK edge.
- R8: Capture-DR, update-DR, loss of select and test-logic-reset return the parser to search and force CS_N high. Test-logic-reset does this asynchronously, and it is also the reset state.
- R9: A length of zero ends the frame with no CS_N assertion and no SCLK edge.
- R10: If shift-DR ends before L payload bits have been taken, the transfer is aborted. CS_N goes high, and the SCLK count equals the number of payload bits shifted.
- R11: After a completed, zero-length or aborted frame, the next scan starts a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | Test-logic-reset state, asynchronous, active high |
| sel | input | 1 | Bridge instruction selected |
| capture_dr | input | 1 | TAP in capture-DR |
| shift_dr | input | 1 | TAP in shift-DR |
| update_dr | input | 1 | TAP in update-DR |
| tdi | input | 1 | Scan data in |
| tdo | output | 1 | Scan data out, changes on falling TCK |
| sclk | output | 1 | SPI clock, gated TCK |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |

## Verification
Two events can fall in the same TCK edge: the rising SCLK edge that clocks the last payload bit, and the end of the scan (or a loss of shift, as in an abort). The bench ends scans with no trailing bits, with trailing bits, and part way through the payload. It counts SCLK edges in a model of a flash shift register. A correct edge count and a correct CS_N window in every cycle show that neither an SCLK edge is lost nor an extra one is added. TDO is compared on every cycle against a model that switches between the bypass path and the MISO path in the cycle the window opens and closes.

// File: rtl/scan_flash_bridge.sv
module scan_flash_bridge #(
  parameter int LEN_W = 32
) (
  input  logic tck,
  input  logic tlr,
  input  logic sel,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic tdi,
  output logic tdo,
  output logic sclk,
  output logic cs_n,
  output logic mosi,
  input  logic miso
);
  localparam int CNT_W = $clog2(LEN_W);

  typedef enum logic [1:0] {HUNT, HDR, XFER, DONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] hdr_cnt;
  logic [LEN_W-1:0] hdr_sr, remain;
  logic             bit_valid, tdi_q, dr, en;

  wire              live    = sel & shift_dr & ~capture_dr & ~update_dr;
  wire              leave   = ~sel | capture_dr | update_dr;
  wire [LEN_W-1:0]  hdr_val = {hdr_sr[LEN_W-2:0], tdi};
  wire              hdr_last = (hdr_cnt == CNT_W'(LEN_W-1));

  always_ff @(posedge tck or posedge tlr) begin
    if (tlr) begin
      st        <= HUNT;
      hdr_cnt   <= '0;
      hdr_sr    <= '0;
      remain    <= '0;
      bit_valid <= 1'b0;
      tdi_q     <= 1'b0;
      dr        <= 1'b0;
    end else begin
      bit_valid <= (st == XFER) && live;
      tdi_q     <= tdi;
      dr        <= en ? miso : tdi;
      if (leave) st <= HUNT;
      else begin
        case (st)
          HUNT: if (shift_dr && tdi) begin
            st      <= HDR;
            hdr_cnt <= '0;
          end
          HDR: if (!shift_dr) st <= HUNT;
          else begin
            hdr_sr  <= hdr_val;
            hdr_cnt <= hdr_cnt + 1'b1;
            if (hdr_last) begin
              remain <= hdr_val;
              st     <= (hdr_val == '0) ? DONE : XFER;
            end
          end
          XFER: if (!shift_dr) st <= HUNT;
          else begin
            remain <= remain - 1'b1;
            if (remain == LEN_W'(1)) st <= DONE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(negedge tck or posedge tlr) begin
    if (tlr) begin
      en   <= 1'b0;
      cs_n <= 1'b1;
      mosi <= 1'b0;
      tdo  <= 1'b0;
    end else begin
      en   <= bit_valid;
      cs_n <= ~bit_valid;
      mosi <= tdi_q;
      tdo  <= dr;
    end
  end

  assign sclk = tck & en;

  AST_CAPTURE_RELEASES_CS: assert property (@(posedge tck) disable iff (tlr)
    capture_dr |=> cs_n) else $error("capture did not release CS_N"); // R8

  AST_DESELECT_TO_HUNT: assert property (@(posedge tck) disable iff (tlr)
    !sel |=> (st == HUNT)) else $error("deselect did not reset parser"); // R8

  AST_XFER_COUNT_LIVE: assert property (@(posedge tck) disable iff (tlr)
    (st == XFER) |-> (remain != '0)) else $error("transfer with no count left"); // R3

  AST_ZERO_LEN_SKIPS: assert property (@(posedge tck) disable iff (tlr)
    (st == HDR && live && hdr_last && hdr_val == '0) |=> (st == DONE && cs_n))
    else $error("zero length opened a transfer"); // R9

  AST_SHIFT_LOSS_ABORTS: assert property (@(posedge tck) disable iff (tlr)
    (st == XFER && !leave && !shift_dr) |=> (st == HUNT && cs_n))
    else $error("early shift exit did not abort"); // R10

endmodule

// File: tb/test_scan_flash_bridge.sv
module test_scan_flash_bridge;
  logic tck = 0, tlr = 1, sel = 0, cap = 0, sh = 0, upd = 0, tdi = 0, miso = 0;
  wire  tdo, sclk, cs_n, mosi;

  always #5 tck = ~tck;

  scan_flash_bridge i_scan_flash_bridge (
    .tck(tck), .tlr(tlr), .sel(sel), .capture_dr(cap), .shift_dr(sh),
    .update_dr(upd), .tdi(tdi), .tdo(tdo), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso));

  int checks = 0, errors = 0;

  // behavioural flash: shift register target
  int          sclk_cnt = 0;
  logic        got_q[$];
  logic [63:0] pat;
  int          pidx;
  always @(posedge sclk) begin sclk_cnt++; got_q.push_back(mosi); end
  always @(negedge cs_n) begin pidx = 0; miso = pat[0]; end
  always @(negedge sclk) if (!cs_n) begin pidx++; miso = pat[pidx % 64]; end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // z leading zeros, length L, d payload/flush bits shifted, kill = cycle of tlr pulse (-1 none)
  task automatic run_frame(int z, int L, int d, int kill);
    logic b[$];
    int n, last, cnt;
    pat = {$urandom, $urandom};
    sclk_cnt = 0;
    got_q.delete();
    for (int i = 0; i < z; i++) b.push_back(1'b0);
    b.push_back(1'b1);
    for (int i = 31; i >= 0; i--) b.push_back(L[i]);
    for (int i = 0; i < d; i++) b.push_back(1'($urandom));
    n = b.size();
    last = z + 32 + ((L < d) ? L : d);
    @(negedge tck); #1 sel = 1; cap = 1;
    for (int k = 0; k <= n + 2; k++) begin
      @(negedge tck); #1;
      cap = 0;
      sh  = (k < n);
      upd = (k == n + 1);
      tdi = (k < n) ? b[k] : 1'b0;
      #3;
      if (k == kill) begin
        tlr = 1; #1;
        check(cs_n === 1'b1, "R8", "cs_n after test-logic-reset", cs_n, 1);
        cnt = sclk_cnt;
        sh = 0; tlr = 0;
        repeat (4) @(negedge tck);
        check(sclk_cnt == cnt, "R8", "sclk edges after test-logic-reset", sclk_cnt, cnt);
        break;
      end
      begin
        bit exp_low = (k - 1 >= z + 33) && (k - 1 <= last);
        check(cs_n === !exp_low, exp_low ? "R3" : "R5", "cs_n per cycle", cs_n, !exp_low);
      end
      if (k >= 1 && k <= n) begin
        int p = k - 1;
        if (p >= z + 34 && p <= last + 1)
          check(tdo === pat[p - z - 34], "R7", "tdo returns miso", tdo, pat[p - z - 34]);
        else
          check(tdo === b[p], "R6", "tdo bypass delay", tdo, b[p]);
      end
    end
    @(negedge tck); #1 upd = 0; sel = 0;
    if (kill < 0) begin
      int exp_cnt = (L < d) ? L : d;
      check(sclk_cnt == exp_cnt, (d < L) ? "R10" : ((L == 0) ? "R9" : "R2 R3"),
            "sclk edge count", sclk_cnt, exp_cnt);
      for (int j = 0; j < got_q.size() && j < exp_cnt; j++)
        check(got_q[j] === b[z + 33 + j], "R4", "mosi bit order", got_q[j], b[z + 33 + j]);
      check(cs_n === 1'b1, "R5", "cs_n after frame", cs_n, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge tck);
    check(cs_n === 1'b1 && sclk === 1'b0, "R8", "reset state cs_n/sclk", {cs_n, sclk}, 2);
    @(negedge tck); tlr = 0;
    // R1: ones while deselected do not start a frame
    sclk_cnt = 0;
    for (int k = 0; k < 45; k++) begin
      @(negedge tck); #1 sh = 1; tdi = 1; #3;
      check(cs_n === 1'b1, "R1", "cs_n while deselected", cs_n, 1);
    end
    @(negedge tck); #1 sh = 0; tdi = 0;
    check(sclk_cnt == 0, "R1", "sclk while deselected", sclk_cnt, 0);
    run_frame(0, 8, 11, -1);
    run_frame(5, 16, 19, -1);
    run_frame(37, 1, 1, -1);
    run_frame(3, 0, 5, -1);          // R9
    run_frame(2, 20, 7, -1);         // R10
    run_frame(4, 12, 14, -1);        // R11 after abort
    for (int r = 0; r < 6; r++)
      run_frame($urandom_range(0, 20), $urandom_range(1, 40), 0, -1 - 0 * r) ;
    for (int r = 0; r < 6; r++) begin
      int L = $urandom_range(1, 40);
      run_frame($urandom_range(0, 20), L, L + $urandom_range(0, 8), -1);
    end
    run_frame(1, 30, 40, 40);        // R8 test-logic-reset mid transfer
    run_frame(6, 9, 12, -1);         // R11 after reset
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule